// File: doc/BRIEF.md
# Montgomery Domain Factor Calculator

This block produces the constant that moves operands into the Montgomery domain: the value 2^(2·L·W) reduced modulo an L-word modulus N, where W is the word width. It uses no multiplier. A running value starts at one and is doubled 2·L·W times. After each doubling it is reduced by at most one subtraction of N, so it stays below N throughout.

The modulus sits in an external register file. The block requests one word per cycle on `n_addr` and expects that word on `n_word` in the same cycle, so the file must have an asynchronous read. Each doubling is a single pass over the L words, least significant word first. The pass writes the shifted word into one storage bank and the shifted word minus N into the other. At the end of the pass, the carry shifted out of the top and the borrow out of the subtraction together decide which bank becomes current. A run takes exactly 2·L·W·L cycles. The result stays in place until the next start and can be read one word at a time through `f_addr`/`f_word`.

Top module: `mont_factor_calc`

## Requirements
- R1: After reset, and whenever `rst_n` is low, `busy` and `done` are both 0.
- R2: A `start` pulse sampled while `busy` is 0 makes `busy` 1 and `done` 0 from the next cycle on.
- R3: When `done` rises, the words read through `f_addr` = j (j = 0 is the least significant word, W bits each) form 2^(2·L·W) mod N for any modulus 2 ≤ N < 2^(L·W).
- R4: `done` rises exactly 2·L·W·L clock cycles after the edge that accepted `start`, with no dependence on the value of N.
- R5: While `busy` is 1, `n_addr` counts 0, 1, …, L−1 and wraps to 0, advancing by one on every clock cycle. It is 0 in the first busy cycle.
- R6: A `start` pulse while `busy` is 1 is ignored. The run finishes at its original time with the same result.
- R7: After `done` rises it stays 1, `busy` stays 0 and the factor words keep their values until the next `start`.
- R8: `busy` and `done` are never 1 at the same time.
- R9: A `start` after `done` begins a fresh computation from one. The new result depends only on the new modulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a computation |
| n_addr | output | $clog2(L) | Index of the modulus word wanted this cycle |
| n_word | input | W | Modulus word at `n_addr`, same cycle |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Result valid, held until next start |
| f_addr | input | $clog2(L) | Index of the factor word to read |
| f_word | output | W | Factor word at `f_addr` (combinational) |

## Verification
A wrong keep-or-replace decision after any doubling leaves the running value wrong from that point on. The error does not cancel out, so it shows in the final factor words when `done` rises and not before. The bench therefore compares the whole factor against an independently computed wide remainder for moduli chosen to stress the carry-out path (top bit set, all ones) and the borrow path (small moduli). A miscounted word or iteration counter shows at once as a broken `n_addr` sequence or a `done` that arrives off the exact cycle count. A bank-select error after completion shows as factor words that change while `done` is held.

// File: rtl/mfc_pkg.sv
`timescale 1ns/1ps
package mfc_pkg;
  typedef enum logic [1:0] {
    MFC_IDLE = 2'd0,
    MFC_RUN  = 2'd1,
    MFC_DONE = 2'd2
  } mfc_state_e;

  // carry and borrow chained across the words of one pass
  typedef struct packed {
    logic carry;
    logic borrow;
  } mfc_chain_t;
endpackage

// File: rtl/mfc_ctrl.sv
`timescale 1ns/1ps
module mfc_ctrl #(
  parameter int W = 16,
  parameter int L = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic                  busy,
  output logic                  done,
  output logic                  init,
  output logic                  pass_end,
  output logic [((L>1)?$clog2(L):1)-1:0] word_idx
);
  import mfc_pkg::*;

  localparam int AW    = (L > 1) ? $clog2(L) : 1;
  localparam int ITERS = 2 * L * W;
  localparam int IW    = $clog2(ITERS + 1);

  mfc_state_e    state_q;
  logic [AW-1:0] word_q;
  logic [IW-1:0] iter_q;
  logic          last_word;
  logic          last_iter;

  assign busy      = (state_q == MFC_RUN);
  assign done      = (state_q == MFC_DONE);
  assign last_word = (word_q == AW'(L - 1));
  assign last_iter = (iter_q == IW'(ITERS - 1));
  assign init      = start && !busy;
  assign pass_end  = busy && last_word;
  assign word_idx  = word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= MFC_IDLE;
      word_q  <= '0;
      iter_q  <= '0;
    end else if (init) begin
      state_q <= MFC_RUN;
      word_q  <= '0;
      iter_q  <= '0;
    end else if (busy) begin
      if (last_word) begin
        word_q <= '0;
        if (last_iter) state_q <= MFC_DONE;
        else           iter_q  <= iter_q + 1'b1;
      end else begin
        word_q <= word_q + 1'b1;
      end
    end
  end

  // iteration counter never exceeds its bound while running
  assert_iter_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (iter_q < IW'(ITERS)));

  // the run ends only on the last word of the last iteration
  assert_done_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(last_iter) && $past(last_word) && $past(busy)));

  // an accepted start always opens a run at word 0
  assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && word_q == '0));
endmodule

// File: rtl/mfc_word_step.sv
`timescale 1ns/1ps
module mfc_word_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] cur_word,
  input  logic [W-1:0] mod_word,
  input  mfc_pkg::mfc_chain_t chain_in,
  output logic [W-1:0] shifted,
  output logic [W-1:0] diff,
  output mfc_pkg::mfc_chain_t chain_out
);
  import mfc_pkg::*;

  // shift left by one, feed carry in at the bottom; returns {carry_out, word}
  function automatic logic [W:0] shl_word(input logic [W-1:0] a, input logic cin);
    return {a, cin};
  endfunction

  // a - b - bin; returns {borrow_out, difference}
  function automatic logic [W:0] sub_word(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic bin);
    logic [W:0] wide;
    wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, bin};
    return wide;
  endfunction

  logic [W:0] sh_res;
  logic [W:0] sb_res;

  always_comb begin
    sh_res           = shl_word(cur_word, chain_in.carry);
    sb_res           = sub_word(sh_res[W-1:0], mod_word, chain_in.borrow);
    shifted          = sh_res[W-1:0];
    diff             = sb_res[W-1:0];
    chain_out.carry  = sh_res[W];
    chain_out.borrow = sb_res[W];
  end
endmodule

// File: rtl/mfc_bank.sv
`timescale 1ns/1ps
module mfc_bank #(
  parameter int W = 16,
  parameter int L = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  init,
  input  logic                  step_en,
  input  logic                  flip,
  input  logic [((L>1)?$clog2(L):1)-1:0] step_idx,
  input  logic [W-1:0]          keep_word,
  input  logic [W-1:0]          alt_word,
  input  logic [((L>1)?$clog2(L):1)-1:0] rd_idx,
  output logic [W-1:0]          step_word,
  output logic [W-1:0]          rd_word,
  output logic                  cur_sel
);
  localparam int AW = (L > 1) ? $clog2(L) : 1;

  logic [W-1:0] store_q [2][L];
  logic         sel_q;

  assign cur_sel   = sel_q;
  assign step_word = store_q[sel_q][step_idx];
  assign rd_word   = store_q[sel_q][rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      for (int b = 0; b < 2; b++)
        for (int j = 0; j < L; j++)
          store_q[b][j] <= '0;
    end else if (init) begin
      sel_q <= 1'b0;
      for (int j = 0; j < L; j++)
        store_q[0][j] <= (j == 0) ? W'(1) : '0;
    end else if (step_en) begin
      store_q[sel_q][step_idx]  <= keep_word;
      store_q[!sel_q][step_idx] <= alt_word;
      if (flip) sel_q <= !sel_q;
    end
  end

  // the current bank changes only at the end of a pass or on init
  assert_sel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !(step_en && flip)) |=> $stable(sel_q));

  // index used for stepping stays inside the array
  assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |-> (step_idx <= AW'(L - 1)));
endmodule

// File: rtl/mont_factor_calc.sv
`timescale 1ns/1ps
module mont_factor_calc #(
  parameter int W = 16,
  parameter int L = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic [((L>1)?$clog2(L):1)-1:0] n_addr,
  input  logic [W-1:0]          n_word,
  output logic                  busy,
  output logic                  done,
  input  logic [((L>1)?$clog2(L):1)-1:0] f_addr,
  output logic [W-1:0]          f_word
);
  import mfc_pkg::*;

  localparam int AW = (L > 1) ? $clog2(L) : 1;

  logic          init;
  logic          pass_end;
  logic [AW-1:0] word_idx;
  logic [W-1:0]  cur_word;
  logic [W-1:0]  shifted;
  logic [W-1:0]  diff;
  mfc_chain_t    chain_q;
  mfc_chain_t    chain_nx;
  logic          step_keep;
  logic          step_flip;
  logic          cur_sel;

  mfc_ctrl #(.W(W), .L(L)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .init     (init),
    .pass_end (pass_end),
    .word_idx (word_idx)
  );

  assign n_addr = word_idx;

  mfc_word_step #(.W(W)) step_i (
    .cur_word  (cur_word),
    .mod_word  (n_word),
    .chain_in  (chain_q),
    .shifted   (shifted),
    .diff      (diff),
    .chain_out (chain_nx)
  );

  // keep the doubled value only if it is below N: borrow out, no carry out
  assign step_keep = chain_nx.borrow && !chain_nx.carry;
  assign step_flip = pass_end && !step_keep;

  always_ff @(posedge clk) begin
    if (!rst_n || init || pass_end) chain_q <= '0;
    else if (busy)                  chain_q <= chain_nx;
  end

  mfc_bank #(.W(W), .L(L)) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (init),
    .step_en   (busy),
    .flip      (step_flip),
    .step_idx  (word_idx),
    .keep_word (shifted),
    .alt_word  (diff),
    .rd_idx    (f_addr),
    .step_word (cur_word),
    .rd_word   (f_word),
    .cur_sel   (cur_sel)
  );

  assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_naddr_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && n_addr != AW'(L - 1)) |=> (busy && n_addr == $past(n_addr) + 1'b1));

  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !pass_end) |=> busy);

  assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(cur_sel)));

  assert_chain_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pass_end |=> (chain_q == '0));

  always_comb begin
    if (rst_n) begin
      assert_reset_quiet_R1: assert (!(busy && done));
    end
  end
endmodule

// File: tb/mont_factor_calc_tb.sv
`timescale 1ns/1ps
module mont_factor_calc_tb_top;
  localparam int W      = 16;
  localparam int L      = 4;
  localparam int AW     = (L > 1) ? $clog2(L) : 1;
  localparam int LW     = L * W;
  localparam int T_RUN  = 2 * L * W * L;
  localparam int NVEC_N = 6;

  // modulus vectors: carry-out path, borrow path, mixed
  localparam logic [LW-1:0] NVEC [NVEC_N] = '{
    64'hFFFF_FFFF_FFFF_FFFF,
    64'h8000_0000_0000_0001,
    64'h0000_0000_0000_0003,
    64'hC96F_3A27_5B1D_E8A5,
    64'h0000_0000_0001_0001,
    64'h7FFF_FFFF_FFFF_FFFF
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] n_addr;
  logic [W-1:0]  n_word;
  logic          busy;
  logic          done;
  logic [AW-1:0] f_addr = '0;
  logic [W-1:0]  f_word;
  logic [W-1:0]  nmem [L];

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign n_word = nmem[n_addr];

  mont_factor_calc #(.W(W), .L(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .n_addr(n_addr), .n_word(n_word),
    .busy(busy), .done(done), .f_addr(f_addr), .f_word(f_word)
  );

  function automatic logic [LW-1:0] ref_factor(input logic [LW-1:0] n);
    logic [2*LW:0] p;
    logic [2*LW:0] m;
    p = '0;
    p[2*LW] = 1'b1;
    m = {{(LW+1){1'b0}}, n};
    return LW'(p % m);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [LW-1:0] act,
                     input logic [LW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_factor(output logic [LW-1:0] got);
    got = '0;
    for (int j = 0; j < L; j++) begin
      f_addr = AW'(j);
      #1;
      got[j*W +: W] = f_word;
    end
  endtask

  task automatic load_mod(input logic [LW-1:0] n);
    for (int j = 0; j < L; j++) nmem[j] = n[j*W +: W];
  endtask

  task automatic run_case(input logic [LW-1:0] n, input int poke, input string tag);
    int cycles;
    int addr_bad;
    int excl_bad;
    logic [LW-1:0] got;
    load_mod(n);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !done, "R2", {62'd0, busy, done}, 64'd2);
    cycles = 0; addr_bad = 0; excl_bad = 0;
    while (!done && cycles < T_RUN + 50) begin
      if (busy && n_addr != AW'(cycles % L)) addr_bad++;
      start = (poke != 0 && cycles == poke);
      @(negedge clk);
      cycles++;
      if (busy && done) excl_bad++;
    end
    start = 1'b0;
    chk(cycles == T_RUN, "R4", LW'(cycles), LW'(T_RUN));
    chk(addr_bad == 0, "R5", LW'(addr_bad), 64'd0);
    chk(excl_bad == 0, "R8", LW'(excl_bad), 64'd0);
    read_factor(got);
    chk(got == ref_factor(n), tag, got, ref_factor(n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [LW-1:0] first;
    logic [LW-1:0] again;
    load_mod('0);
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1", {62'd0, busy, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1", {62'd0, busy, done}, 64'd0);

    // table walk: R3 on each modulus, later runs also cover restart (R9)
    for (int i = 0; i < NVEC_N; i++)
      run_case(NVEC[i], 0, (i == 0) ? "R3" : "R9");

    // smallest legal moduli
    run_case(64'd2, 0, "R3");
    run_case(64'd3, 0, "R3");

    // start pulses while busy are ignored
    run_case(64'hC96F_3A27_5B1D_E8A5, 100, "R6");
    run_case(64'h8000_0000_0000_0001, T_RUN - 3, "R6");

    // result held after done
    read_factor(first);
    repeat (25) @(negedge clk);
    chk(done && !busy, "R7", {62'd0, busy, done}, 64'd1);
    read_factor(again);
    chk(again == first, "R7", again, first);

    // reset after done clears the flags
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R1", {62'd0, busy, done}, 64'd0);
    rst_n = 1'b1;

    // reset during a run returns to idle
    load_mod(64'h0000_0000_0000_0003);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R1", {62'd0, busy, done}, 64'd0);
    rst_n = 1'b1;
    run_case(64'h7FFF_FFFF_FFFF_FFFF, 0, "R9");

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule